// File: doc/BRIEF.md
# Serial Control-Register Slave with Auto-Incrementing Pointer

This block is a two-wire serial slave that gives a host controller access to a small bank of 8-bit control registers. It oversamples SCL and SDA in the system clock domain, finds start, repeated-start and stop conditions, compares the incoming device address with a 7-bit parameter, and pulls an open-drain SDA low for acknowledges and for read data bits. The register contents are always visible on a flat parallel output, so the rest of the chip reads its configuration directly from the bank.

In a write-addressed frame the first byte after the device address sets an internal register pointer. Any further bytes in that frame are stored at the pointer, and the pointer advances after each one. A read-addressed frame returns bytes starting at whatever pointer value was stored last. A random read is therefore a write frame that carries only the pointer byte, then a repeated start and a read frame. The pointer also advances after each byte it sends, and it wraps from the last register to register 0.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, register i holds (RST_BASE + i*RST_STEP) mod 256 (defaults 0x80 and 0x11, so 0x80, 0x91, 0xA2, ...) and SDA is released.
- R2: An address byte is shifted in MSB first. Bits 7:1 are the device address and bit 0 is the direction, 0 for write and 1 for read. When bits 7:1 equal DEV_ADDR (default 0x4C), the slave pulls SDA low through the ninth clock.
- R3: After an address byte that does not match, SDA stays released and no register changes until the next start or stop.
- R4: In a write frame, the first byte after the address is acknowledged and loads the pointer from its low log2(NREGS) bits. It changes no register.
- R5: Each later byte in a write frame is acknowledged and stored at the pointer, and then the pointer advances by one.
- R6: The pointer survives both repeated start and stop. A read frame starts returning data at the stored pointer.
- R7: In a read frame the slave puts each register out MSB first and changes SDA only while SCL is low. It releases SDA for the ninth clock and advances the pointer after each byte.
- R8: When the host answers a read byte with NACK (SDA high on the ninth clock), the slave stops driving, and SDA stays released for any further clocks until a start.
- R9: A stop (SDA rising while SCL is high) ends the transfer. Bits clocked in after the stop without a new start are neither acknowledged nor stored.
- R10: The pointer wraps from NREGS-1 to 0, for both writes and reads.
- R11: regs_q[i*8 +: 8] always shows the current content of register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_q | output | NREGS*8 | Flat view of all registers, register i at bits i*8 +: 8 |

## Verification
The bench goes after the pointer and the points where a transfer changes direction or ends.

- **Pointer lost across start or stop.** A read frame sent with no preceding pointer byte must return the register just after the last write. A design that clears the pointer on start or stop would return register 0 instead.
- **Pointer wrap.** A four-byte burst from base 6, written and then read back, shows whether the pointer wraps. A design without the wrap would corrupt the burst or read it back in the wrong order.
- **Pointer byte stored as data.** Storing the pointer byte as data would corrupt a register.
- **Masked pointer byte.** A pointer byte with high bits set shows whether the design ignores bits above log2(NREGS).
- **NACK.** Extra clocks after a NACK, and a byte clocked in after a stop, expose a slave that keeps driving SDA or keeps listening.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_RXB,
      ST_ACK,
      ST_TXB,
      ST_MACK
   } rb_state_e;
endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_ch, sda_ch;
   logic              scl_d, sda_d;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_rb_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ch <= '1;
         sda_ch <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ch <= {scl_ch[STAGES-2:0], scl_i};
         sda_ch <= {sda_ch[STAGES-2:0], sda_i};
         scl_d  <= scl_ch[STAGES-1];
         sda_d  <= sda_ch[STAGES-1];
      end
   end

   assign scl_q     = scl_ch[STAGES-1];
   assign sda_q     = sda_ch[STAGES-1];
   assign scl_rise  = scl_q & ~scl_d;
   assign scl_fall  = ~scl_q & scl_d;
   assign start_det = scl_q & scl_d & sda_d & ~sda_q;
   assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs #(
   parameter int NREGS    = 8,
   parameter int DW       = 8,
   parameter int RST_BASE = 8'h80,
   parameter int RST_STEP = 8'h11,
   localparam int AW      = $clog2(NREGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [AW-1:0]       waddr,
   input  logic [DW-1:0]       wdata,
   input  logic [AW-1:0]       raddr,
   output logic [DW-1:0]       rdata,
   output logic [NREGS*DW-1:0] q_flat
);
   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      localparam logic [DW-1:0] RST_VAL = DW'(RST_BASE + i * RST_STEP);
      logic [DW-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          r <= RST_VAL;
         else if (we && waddr == AW'(i))      r <= wdata;
      end
      assign q_flat[i*DW +: DW] = r;
   end

   assign rdata = q_flat[raddr*DW +: DW];
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
   import i2c_rb_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h4C,
   parameter int         NREGS       = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         RST_BASE    = 8'h80,
   parameter int         RST_STEP    = 8'h11,
   localparam int        BW          = 8,
   localparam int        AW          = $clog2(NREGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_in,
   input  logic                sda_in,
   output logic                sda_oe,
   output logic [NREGS*BW-1:0] regs_q
);
   if (NREGS < 2 || NREGS > 256 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
      $error("i2c_regbank_slave: NREGS must be a power of two in 2..256");
   end

   logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   rb_state_e     state;
   logic [2:0]    bitcnt;
   logic [BW-1:0] sh, tx, rdata, rx_byte;
   logic [AW-1:0] ptr;
   logic          rw_q, base_pending, ackph, reg_we;

   i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_in), .sda_i(sda_in),
      .scl_q(scl_s), .sda_q(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   assign rx_byte = {sh[BW-2:0], sda_s};
   assign reg_we  = (state == ST_RXB) && scl_rise && (bitcnt == 3'd7)
                    && !base_pending && !start_det && !stop_det;

   i2c_rb_regs #(.NREGS(NREGS), .DW(BW), .RST_BASE(RST_BASE), .RST_STEP(RST_STEP)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(ptr), .wdata(rx_byte),
      .raddr(ptr), .rdata(rdata), .q_flat(regs_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         bitcnt       <= '0;
         sh           <= '0;
         tx           <= '0;
         ptr          <= '0;
         rw_q         <= 1'b0;
         base_pending <= 1'b0;
         ackph        <= 1'b0;
         sda_oe       <= 1'b0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         state  <= ST_ADDR;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else begin
         case (state)
            ST_ADDR: if (scl_rise) begin
               sh     <= rx_byte;
               bitcnt <= bitcnt + 3'd1;
               if (bitcnt == 3'd7) begin
                  if (rx_byte[7:1] == DEV_ADDR) begin
                     rw_q         <= rx_byte[0];
                     base_pending <= ~rx_byte[0];
                     ackph        <= 1'b0;
                     state        <= ST_ACK;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_RXB: if (scl_rise) begin
               sh     <= rx_byte;
               bitcnt <= bitcnt + 3'd1;
               if (bitcnt == 3'd7) begin
                  if (base_pending) ptr <= rx_byte[AW-1:0];
                  else              ptr <= ptr + 1'b1;
                  base_pending <= 1'b0;
                  ackph        <= 1'b0;
                  state        <= ST_ACK;
               end
            end
            ST_ACK: if (scl_fall) begin
               if (!ackph) begin
                  sda_oe <= 1'b1;
                  ackph  <= 1'b1;
               end else begin
                  bitcnt <= '0;
                  if (rw_q) begin
                     tx     <= rdata;
                     sda_oe <= ~rdata[BW-1];
                     state  <= ST_TXB;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_RXB;
                  end
               end
            end
            ST_TXB: if (scl_fall) begin
               bitcnt <= bitcnt + 3'd1;
               if (bitcnt == 3'd7) begin
                  sda_oe <= 1'b0;
                  ptr    <= ptr + 1'b1;
                  ackph  <= 1'b0;
                  state  <= ST_MACK;
               end else begin
                  sda_oe <= ~tx[BW-2];
                  tx     <= {tx[BW-2:0], 1'b0};
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  if (sda_s) state <= ST_IDLE;
                  else       ackph <= 1'b1;
               end else if (scl_fall && ackph) begin
                  tx     <= rdata;
                  sda_oe <= ~rdata[BW-1];
                  bitcnt <= '0;
                  state  <= ST_TXB;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_rb_checker.sv
module i2c_rb_checker
   import i2c_rb_pkg::*;
#(
   parameter int AW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_s,
   input logic          start_det,
   input logic          stop_det,
   input logic          sda_oe,
   input rb_state_e     state,
   input logic          reg_we,
   input logic [AW-1:0] ptr
);
   assert_drive_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE && !sda_oe));

   assert_start_keeps_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_ADDR && ptr == $past(ptr)));

   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> ptr == AW'($past(ptr) + 1'b1));

   assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);
endmodule

bind i2c_regbank_slave i2c_rb_checker #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
   .stop_det(stop_det), .sda_oe(sda_oe), .state(state), .reg_we(reg_we), .ptr(ptr)
);

// File: tb/sim_i2c_regbank_slave.sv
module sim_i2c_regbank_slave;
   localparam int NR = 8;
   localparam int Q  = 6;
   localparam logic [7:0] AW_BYTE = 8'h98;
   localparam logic [7:0] AR_BYTE = 8'h99;
   localparam logic [15:0] VEC [6] = '{16'h0012, 16'h03A5, 16'h0D3C, 16'h07FF, 16'h0400, 16'h015A};

   logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
   logic sda_oe, sda_bus;
   logic [NR*8-1:0] regs_q;
   logic [7:0] model [NR];
   logic [7:0] wbuf [4];
   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   i2c_regbank_slave u0 (.clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
                         .sda_oe(sda_oe), .regs_q(regs_q));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n); repeat (n) @(negedge clk); endtask
   task automatic bstart(); sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q); endtask
   task automatic bstop(); sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q); endtask

   task automatic put_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
      end
      sda_m = 1; tick(Q); scl_m = 1; tick(Q); ack = ~sda_bus; tick(Q); scl_m = 0; tick(Q);
   endtask

   task automatic get_byte(input logic give_ack, output logic [7:0] b);
      sda_m = 1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q); scl_m = 1; tick(Q); b[i] = sda_bus; tick(Q); scl_m = 0; tick(Q);
      end
      sda_m = ~give_ack; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q); sda_m = 1;
   endtask

   task automatic check_regs(input string tag);
      for (int i = 0; i < NR; i++)
         chk(regs_q[i*8 +: 8] == model[i], tag, regs_q[i*8 +: 8], model[i]);
   endtask

   // write frame: address, pointer byte, n data bytes from wbuf
   task automatic write_seq(input logic [7:0] base, input int n);
      logic a;
      bstart();
      put_byte(AW_BYTE, a); chk(a, "R2 address ack", a, 1);
      put_byte(base, a);    chk(a, "R4 pointer ack", a, 1);
      for (int k = 0; k < n; k++) begin
         put_byte(wbuf[k], a); chk(a, "R5 data ack", a, 1);
         model[(int'(base) + k) % NR] = wbuf[k];
      end
      bstop();
   endtask

   // random read: pointer write, repeated start, n bytes
   task automatic read_seq(input logic [7:0] base, input int n, input string tag);
      logic a;
      logic [7:0] d;
      bstart();
      put_byte(AW_BYTE, a); chk(a, "R2 address ack", a, 1);
      put_byte(base, a);    chk(a, "R4 pointer ack", a, 1);
      bstart();
      put_byte(AR_BYTE, a); chk(a, "R6 read address ack", a, 1);
      for (int k = 0; k < n; k++) begin
         get_byte(k != n-1, d);
         chk(d == model[(int'(base) + k) % NR], tag, d, model[(int'(base) + k) % NR]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] d;
      bit hi;
      for (int i = 0; i < NR; i++) model[i] = 8'(8'h80 + 8'h11 * i);
      tick(5); rst_n = 1; tick(5);
      // R1 reset state
      chk(sda_bus == 1'b1, "R1 SDA released", sda_bus, 1);
      check_regs("R1 reset defaults");

      // table walk: single write then random read of the same register (R4 masks high bits)
      foreach (VEC[v]) begin
         wbuf[0] = VEC[v][7:0];
         write_seq(VEC[v][15:8], 1);
         check_regs("R11 parallel view after write");
         read_seq(VEC[v][15:8], 1, "R6 R7 random read data");
         bstop();
      end

      // R6: read frame with no pointer byte starts at stored pointer (last write base 1 -> 2)
      wbuf[0] = 8'h66; write_seq(8'h01, 1);
      bstart();
      put_byte(AR_BYTE, a); chk(a, "R6 read ack", a, 1);
      get_byte(1'b0, d); chk(d == model[2], "R6 pointer kept across stop", d, model[2]);
      bstop();

      // R10 + R5: burst write wrapping 6,7,0,1 then burst read
      wbuf = '{8'hC1, 8'hC2, 8'hC3, 8'hC4};
      write_seq(8'h06, 4);
      check_regs("R10 wrap on write");
      read_seq(8'h06, 4, "R10 R7 burst read wrap");
      // R8: after NACK the slave keeps SDA released for further clocks
      hi = 1;
      for (int i = 0; i < 9; i++) begin
         tick(Q); scl_m = 1; tick(Q); if (!sda_bus) hi = 0; tick(Q); scl_m = 0; tick(Q);
      end
      chk(hi, "R8 released after NACK", hi, 1);
      bstop();

      // R3: wrong device address -> no ack, nothing stored
      bstart();
      put_byte(8'h42, a); chk(!a, "R3 no ack on mismatch", a, 0);
      put_byte(8'h02, a); chk(!a, "R3 pointer byte ignored", a, 0);
      put_byte(8'hEE, a); chk(!a, "R3 data ignored", a, 0);
      bstop();
      check_regs("R3 registers unchanged");

      // R9: bytes after stop without start are ignored
      put_byte(AW_BYTE, a); chk(!a, "R9 no ack after stop", a, 0);
      put_byte(8'h00, a);
      put_byte(8'h99, a);
      bstop();
      check_regs("R9 registers unchanged");

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule